// File: doc/BRIEF.md
# Census-Hamming Disparity Selector

This block turns a pair of rectified census-signature streams into a disparity map. Each input beat carries the census signature of one left-image pixel together with the signature of the right-image pixel in the same column, in raster order. Start-of-line and start-of-frame flags travel with the first beat of a row or frame. For every left pixel the block scores 128 candidate horizontal offsets. The cost at offset d is the number of differing bits between the left signature at column x and the right signature at column x-d. The block reports the offset with the lowest cost.

The block keeps a per-row window of the most recent right signatures. It computes all candidate costs for one pixel in a single cycle and reduces them in a pipelined minimum tree. One pixel per clock is sustained. A single stall enable holds the whole pipeline when the consumer applies back-pressure, so no result is dropped or repeated.

Top module: `census_disparity_top`

## Requirements
- R1: For a left pixel at column x, the output `out_disp` is the offset d in 0..127, with d <= x, that minimises popcount(left[x] XOR right[x-d]) over the 24-bit signatures of the same row.
- R2: When several offsets share the minimum cost, the smallest of those offsets is output.
- R3: An offset d with x-d < 0 is treated as cost 24 and never beats a valid offset, so `out_disp` never exceeds the pixel's column index within its row.
- R4: A beat with `in_sol` or `in_sof` high starts a new row. Right signatures from earlier rows take no part in any later cost.
- R5: With `out_ready` held high, `in_ready` stays high, and the result of a pixel accepted at clock edge k is presented with `out_valid` high right after edge k+7 (eight register stages).
- R6: While `out_valid` is high and `out_ready` is low, `out_disp`, `out_sol` and `out_sof` hold and `in_ready` is low. Every accepted pixel yields exactly one result, in input order.
- R7: `out_sol` and `out_sof` accompany the result of the pixel that carried the marker. `out_sof` implies `out_sol`.
- R8: After synchronous reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts the beat at this edge |
| in_left_sig | input | 24 | Left census signature, column x |
| in_right_sig | input | 24 | Right census signature, column x |
| in_sol | input | 1 | First pixel of a row |
| in_sof | input | 1 | First pixel of a frame (also starts a row) |
| out_valid | output | 1 | Disparity result valid |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_disp | output | 7 | Winning offset |
| out_sol | output | 1 | Result belongs to the first pixel of a row |
| out_sof | output | 1 | Result belongs to the first pixel of a frame |

## Verification
The bench targets several ways the block can fail:
- Ties resolved to the larger offset show up on rows of identical or periodic signatures, where the expected winner is 0 or x mod 3.
- Window entries left over from the previous row, or offsets reaching left of column 0 that are not forced out, show up on a row with zero left signatures and all-ones right signatures. Such a design reports a non-zero offset there instead of 0.
- Planted matches at offsets 5, 77 and 127 expose an off-by-one in the window shift as a wrong offset.
- Random back-pressure exposes lost or repeated results.
- A single isolated pixel exposes a latency that is not eight stages.

// File: rtl/census_disp_pkg.sv
package census_disp_pkg;

    localparam int unsigned CD_SIG_W = 24;
    localparam int unsigned CD_NDISP = 128;

    typedef struct packed {
        logic sol;
        logic sof;
    } line_tag_t;

    function automatic int unsigned ones_cnt(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/census_cost_bank.sv
module census_cost_bank
    import census_disp_pkg::*;
#(
    parameter int unsigned SIG_W  = CD_SIG_W,
    parameter int unsigned NDISP  = CD_NDISP,
    parameter int unsigned COST_W = $clog2(SIG_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    accept,
    input  logic                    line_start,
    input  logic [SIG_W-1:0]        left_sig,
    input  logic [SIG_W-1:0]        right_sig,
    output logic [NDISP*COST_W-1:0] leaf_cost
);

    logic [SIG_W-1:0] win_q [0:NDISP-1];
    logic [SIG_W-1:0] win_n [0:NDISP-1];
    logic [NDISP-1:0] live_q;
    logic [NDISP-1:0] live_n;

    // Window as it stands once the current right signature is shifted in.
    always_comb begin
        win_n[0]  = right_sig;
        live_n[0] = 1'b1;
        for (int d = 1; d < NDISP; d++) begin
            win_n[d]  = win_q[d-1];
            live_n[d] = !line_start && live_q[d-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (accept) begin
            live_q <= live_n;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            win_q <= win_n;
        end
    end

    // Dead window slots (left of column 0 or from an earlier row) get the
    // largest possible cost.
    for (genvar d = 0; d < NDISP; d++) begin : g_cost
        assign leaf_cost[d*COST_W +: COST_W] = live_n[d]
            ? COST_W'(ones_cnt(64'(left_sig ^ win_n[d])))
            : COST_W'(SIG_W);
    end

endmodule

// File: rtl/census_min_tree.sv
module census_min_tree
    import census_disp_pkg::*;
#(
    parameter int unsigned NDISP  = CD_NDISP,
    parameter int unsigned COST_W = 5,
    parameter int unsigned IDX_W  = $clog2(NDISP)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic                    in_take,
    input  line_tag_t               in_tag,
    input  logic [NDISP*COST_W-1:0] leaf_cost,
    output logic                    out_vld,
    output line_tag_t               out_tag,
    output logic [IDX_W-1:0]        out_idx
);

    localparam int unsigned LOG = $clog2(NDISP);

    typedef struct packed {
        logic [COST_W-1:0] cost;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // Heap layout: root at 1, children of i at 2i and 2i+1, leaves at NDISP+d.
    cand_t     node_q [1:2*NDISP-1];
    logic [LOG:0] vld_q;
    line_tag_t tag_q [0:LOG];

    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        return (hi.cost < lo.cost) ? hi : lo;
    endfunction

    for (genvar d = 0; d < NDISP; d++) begin : g_leaf
        always_ff @(posedge clk) begin
            if (adv) begin
                node_q[NDISP+d].cost <= leaf_cost[d*COST_W +: COST_W];
                node_q[NDISP+d].idx  <= IDX_W'(d);
            end
        end
    end

    for (genvar i = 1; i < NDISP; i++) begin : g_node
        always_ff @(posedge clk) begin
            if (adv) begin
                node_q[i] <= pick(node_q[2*i], node_q[2*i+1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[LOG-1:0], in_take};
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            tag_q[0] <= in_tag;
            for (int k = 1; k <= LOG; k++) begin
                tag_q[k] <= tag_q[k-1];
            end
        end
    end

    assign out_vld = vld_q[LOG];
    assign out_tag = tag_q[LOG];
    assign out_idx = node_q[1].idx;

endmodule

// File: rtl/census_disparity_top.sv
module census_disparity_top
    import census_disp_pkg::*;
#(
    parameter int unsigned SIG_W  = CD_SIG_W,
    parameter int unsigned NDISP  = CD_NDISP,
    parameter int unsigned DISP_W = $clog2(NDISP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SIG_W-1:0]  in_left_sig,
    input  logic [SIG_W-1:0]  in_right_sig,
    input  logic              in_sol,
    input  logic              in_sof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DISP_W-1:0] out_disp,
    output logic              out_sol,
    output logic              out_sof
);

    localparam int unsigned COST_W = $clog2(SIG_W + 1);

    logic                    adv;
    logic                    accept;
    logic                    line_start;
    line_tag_t               tag_in;
    line_tag_t               tag_out;
    logic [NDISP*COST_W-1:0] leaf_cost;

    // One enable for every stage: the pipeline moves unless a result waits.
    assign adv        = !out_valid || out_ready;
    assign in_ready   = adv;
    assign accept     = in_valid && adv;
    assign line_start = in_sol || in_sof;
    assign tag_in     = '{sol: line_start, sof: in_sof};

    census_cost_bank #(
        .SIG_W  (SIG_W),
        .NDISP  (NDISP),
        .COST_W (COST_W)
    ) cost_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .line_start (line_start),
        .left_sig   (in_left_sig),
        .right_sig  (in_right_sig),
        .leaf_cost  (leaf_cost)
    );

    census_min_tree #(
        .NDISP  (NDISP),
        .COST_W (COST_W),
        .IDX_W  (DISP_W)
    ) tree_i (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .in_take   (accept),
        .in_tag    (tag_in),
        .leaf_cost (leaf_cost),
        .out_vld   (out_valid),
        .out_tag   (tag_out),
        .out_idx   (out_disp)
    );

    assign out_sol = tag_out.sol;
    assign out_sof = tag_out.sof;

endmodule

// File: rtl/census_disparity_chk.sv
module census_disparity_chk #(
    parameter int unsigned NDISP  = 128,
    parameter int unsigned DISP_W = $clog2(NDISP)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DISP_W-1:0] out_disp,
    input logic              out_sol,
    input logic              out_sof
);

    localparam int unsigned STAGES = $clog2(NDISP) + 1;

    int unsigned inflight_q;
    int unsigned col_q;
    logic        started_q;

    wire took = in_valid && in_ready;
    wire gave = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= 0;
            col_q      <= 0;
            started_q  <= 1'b0;
        end else begin
            if (took && !gave) inflight_q <= inflight_q + 1;
            else if (!took && gave) inflight_q <= inflight_q - 1;
            if (gave) begin
                if (out_sol) begin
                    col_q     <= 1;
                    started_q <= 1'b1;
                end else if (col_q < NDISP) begin
                    col_q <= col_q + 1;
                end
            end
        end
    end

    // R6: a held result does not change
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_disp) && $stable(out_sol) && $stable(out_sof));

    // R6: no input accepted while a result is held
    assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R5: never more pixels in flight than register stages
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= STAGES);

    // R3: first pixel of a row can only match offset 0
    assert_row_head_zero_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sol |-> out_disp == '0);

    // R3: winning offset never reaches left of column 0
    assert_disp_within_col_R3: assert property (@(posedge clk) disable iff (rst)
        started_q && out_valid && !out_sol |-> int'(out_disp) <= int'(col_q));

    // R7: frame start implies line start
    assert_sof_has_sol_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof |-> out_sol);

endmodule

bind census_disparity_top census_disparity_chk #(
    .NDISP  (NDISP),
    .DISP_W (DISP_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_disp  (out_disp),
    .out_sol   (out_sol),
    .out_sof   (out_sof)
);

// File: tb/census_disparity_top_tb_top.sv
module census_disparity_top_tb_top;

    localparam int SW = 24;
    localparam int ND = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_left_sig = '0;
    logic [SW-1:0] in_right_sig = '0;
    logic          in_sol = 1'b0;
    logic          in_sof = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [6:0]    out_disp;
    logic          out_sol;
    logic          out_sof;

    always #4 clk = ~clk;

    census_disparity_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_left_sig  (in_left_sig),
        .in_right_sig (in_right_sig),
        .in_sol       (in_sol),
        .in_sof       (in_sof),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_disp     (out_disp),
        .out_sol      (out_sol),
        .out_sof      (out_sof)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit wd = 1'b0;
    int in_stalls = 0;
    string cur_req = "R1";

    logic [SW-1:0] lrow [0:255];
    logic [SW-1:0] rrow [0:255];
    int q_disp [0:4095];
    bit q_sol  [0:4095];
    bit q_sof  [0:4095];
    int wr = 0;
    int rd = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) wd = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input int x, input bit sol, input bit sof);
        int best = 0;
        int bc = 1000;
        for (int d = 0; d < ND; d++) begin
            int c;
            if (x - d >= 0) c = $countones(lrow[x] ^ rrow[x-d]);
            else c = SW;
            if (c < bc) begin
                bc = c;
                best = d;
            end
        end
        q_disp[wr] = best;
        q_sol[wr] = sol;
        q_sof[wr] = sof;
        wr++;
    endtask

    task automatic observe();
        if (out_valid && out_ready) begin
            if (rd >= wr) begin
                chk(1'b0, "R6", "unexpected extra result", 1, 0);
            end else begin
                chk(int'(out_disp) == q_disp[rd], cur_req, "disparity", int'(out_disp), q_disp[rd]);
                chk(out_sol == q_sol[rd] && out_sof == q_sof[rd], "R7", "markers sol/sof",
                    int'({out_sol, out_sof}), int'({q_sol[rd], q_sof[rd]}));
                rd++;
            end
        end
    endtask

    task automatic stream_row(input int width, input bit first, input int gap_pct, input int stall_pct);
        int x = 0;
        while (x < width && !wd) begin
            @(negedge clk);
            out_ready    = ($urandom_range(99) >= stall_pct);
            in_valid     = ($urandom_range(99) >= gap_pct);
            in_left_sig  = lrow[x];
            in_right_sig = rrow[x];
            in_sol       = (x == 0);
            in_sof       = (x == 0) && first;
            #1;
            observe();
            if (in_valid && !in_ready) in_stalls++;
            if (in_valid && in_ready) begin
                push_exp(x, x == 0, (x == 0) && first);
                x++;
            end
        end
    endtask

    task automatic drain(input int stall_pct);
        int extra = 0;
        while ((rd < wr || extra < 12) && !wd) begin
            @(negedge clk);
            in_valid  = 1'b0;
            out_ready = ($urandom_range(99) >= stall_pct);
            #1;
            observe();
            if (rd >= wr) extra++;
        end
        chk(rd == wr, "R6", "results delivered vs accepted", rd, wr);
    endtask

    task automatic fill_random(input int width);
        for (int x = 0; x < width; x++) begin
            lrow[x] = SW'($urandom);
            rrow[x] = SW'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R8: reset state
        chk(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);

        // R5: latency of an isolated pixel
        begin
            int seen_at = -1;
            @(negedge clk);
            out_ready = 1'b1;
            in_valid = 1'b1; in_sol = 1'b1; in_sof = 1'b1;
            in_left_sig = 24'h5A5A5A; in_right_sig = 24'h0F0F0F;
            #1;
            chk(in_ready == 1'b1, "R5", "in_ready idle", int'(in_ready), 1);
            for (int n = 1; n <= 10; n++) begin
                @(negedge clk);
                in_valid = 1'b0;
                #1;
                if (out_valid && seen_at < 0) begin
                    seen_at = n;
                    chk(out_disp == 7'd0, "R3", "lone pixel offset", int'(out_disp), 0);
                    chk(out_sol && out_sof, "R7", "lone pixel markers", int'({out_sol, out_sof}), 3);
                end
            end
            chk(seen_at == 8, "R5", "latency in negedges after accept", seen_at, 8);
        end

        // R1: random rows, full rate
        cur_req = "R1";
        in_stalls = 0;
        for (int r = 0; r < 3; r++) begin
            fill_random(150);
            stream_row(150, r == 0, 0, 0);
        end
        drain(0);
        chk(in_stalls == 0, "R5", "input stalls with out_ready high", in_stalls, 0);

        // R1: planted exact matches
        foreach (lrow[i]) begin end
        begin
            int dps [3] = '{5, 77, 127};
            for (int k = 0; k < 3; k++) begin
                fill_random(200);
                for (int x = dps[k]; x < 200; x++) rrow[x-dps[k]] = lrow[x];
                stream_row(200, k == 0, 0, 0);
            end
        end
        drain(0);

        // R2: ties
        cur_req = "R2";
        for (int x = 0; x < 140; x++) begin
            lrow[x] = '0;
            rrow[x] = '0;
        end
        stream_row(140, 1'b1, 0, 0);
        for (int x = 0; x < 140; x++) begin
            lrow[x] = '0;
            rrow[x] = (x % 3 == 0) ? 24'h000003 : 24'hFFFFFF;
        end
        stream_row(140, 1'b0, 0, 0);
        drain(0);

        // R3/R4: previous row would match, current row cannot beat cost 24
        cur_req = "R4";
        for (int x = 0; x < 140; x++) begin
            lrow[x] = '0;
            rrow[x] = SW'($urandom) & 24'h00F0F0;
        end
        stream_row(140, 1'b1, 0, 0);
        cur_req = "R3";
        for (int x = 0; x < 140; x++) begin
            lrow[x] = '0;
            rrow[x] = 24'hFFFFFF;
        end
        stream_row(140, 1'b0, 0, 0);
        drain(0);

        // R6: gaps and back-pressure
        cur_req = "R6";
        fill_random(135);
        stream_row(135, 1'b1, 30, 40);
        fill_random(64);
        stream_row(64, 1'b0, 30, 40);
        drain(40);

        if (wd) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, 150000);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule